// File: doc/BRIEF.md
# Command Queue and Escape Scheduler

This block stores command packets that are not video data and decides when each one leaves on the link. Software-side logic writes 24-bit packet headers into a header queue and long-packet payload bytes into a separate byte FIFO. In video mode the scheduler sends short commands only inside a blanking interval that still has room for them. In command mode it drains the queue without waiting for any video timing. A configuration bit chooses one of two transports for queued packets: a high-speed packet handed to the link layer, or a low-power data transfer in escape mode on data lane 0.

The same scheduler also handles entry into and exit from the ultra-low-power state. A request drops whatever is in progress and clears both stores. It tells the pixel path to discard its buffered image data and shifts the ultra-low-power entry code out on the clock lane and every data lane. When the request is released, the scheduler signals that video must restart at a fresh frame. A header whose data type is not supported, or whose length cannot be served, is discarded and raises a one-cycle interrupt.

The header word layout is: bits [7:0] hold the data type, and bits [23:8] hold the word count of a long packet or the two parameter bytes of a short one.

Top module: `cmdq_sched`

## Requirements
- R1: A header written with `hdr_wr` goes into a QDEPTH-entry first-in first-out queue, and a byte written with `pay_wr` goes into a DDEPTH-entry byte FIFO. A write to a full store is ignored, so with QDEPTH=8, nine queued headers release exactly the first eight, in order.
- R2: In command mode (`cfg_cmd_mode`=1, `cfg_lpdt`=0), a supported short header at the queue head is issued as a one-cycle `hs_start`, with `hs_hdr` equal to the written word, in the cycle after the write edge.
- R3: A long header (data type 8'h29 or 8'h39) waits while its word count exceeds the byte FIFO occupancy. Once the payload is present, it issues `hs_start` and then presents exactly word-count payload bytes on `hs_pay_vld` in consecutive cycles.
- R4: In video mode (`cfg_cmd_mode`=0), only short headers are sent, and only while `blank_active`=1 and 4 <= `blank_left`*LANES. Long headers and low-power transfers stay queued.
- R5: The supported data types are short 8'h03, 8'h13, 8'h23, 8'h05, 8'h15, 8'h06, 8'h37 and long 8'h29, 8'h39. Any other header at the head is discarded with a one-cycle `irq_bad_dt` and leaves the byte FIFO untouched.
- R6: With `cfg_cmd_mode`=1 and `cfg_lpdt`=1, a queued packet goes out in low-power mode. The code 8'hE1 is shifted out MSB first over 8 cycles with `esc_data_lanes`=4'b0001 and `esc_clk_lane`=0. The bytes data type, word-count low and word-count high then follow on `lp_byte`, and then the payload. There is never an `hs_start` for such a packet.
- R7: A low-power long packet with a word count of 252 or more, or any long packet whose word count exceeds DDEPTH, is rejected as in R5. A word count of 251 is sent.
- R8: Raising `ulps_req` pulses `img_flush` in the same cycle, aborts any transfer and empties both stores. The code 8'h1E then follows over the next 8 cycles on all data lanes with `esc_clk_lane`=1, and `ulps_active` stays high while the request is held.
- R9: Releasing `ulps_req` while `ulps_active` is high pulses `video_restart` for one cycle, and `ulps_active` is low in the following cycle.
- R10: In any cycle at most one of `hs_start`, `hs_pay_vld`, `esc_code_vld`, `lp_byte_vld`, `ulps_active` is high, and no escape code other than 8'hE1 and 8'h1E is ever produced.
- R11: In reset, all strobes and state outputs are low and both stores are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_cmd_mode | input | 1 | 1 = command mode, 0 = video mode |
| cfg_lpdt | input | 1 | 1 = queued packets go as low-power transfers |
| ulps_req | input | 1 | Ultra-low-power state request (level) |
| blank_active | input | 1 | Video blanking interval in progress |
| blank_left | input | 16 | Remaining blanking budget in byte-clock cycles |
| hdr_wr | input | 1 | Header write strobe |
| hdr_wdata | input | 24 | Header word: [7:0] data type, [23:8] count or parameters |
| pay_wr | input | 1 | Payload byte write strobe |
| pay_wdata | input | 8 | Payload byte |
| hs_start | output | 1 | High-speed packet issue strobe |
| hs_hdr | output | 24 | Header of the issued high-speed packet |
| hs_pay_vld | output | 1 | High-speed payload byte valid |
| hs_pay_byte | output | 8 | High-speed payload byte |
| esc_code_vld | output | 1 | Escape entry code bit valid |
| esc_code_bit | output | 1 | Escape entry code bit, MSB first |
| esc_data_lanes | output | LANES | Data lanes carrying the entry code |
| esc_clk_lane | output | 1 | Clock lane carries the entry code |
| lp_byte_vld | output | 1 | Low-power data byte valid (lane 0) |
| lp_byte | output | 8 | Low-power data byte |
| ulps_active | output | 1 | Clock and all data lanes in ultra-low-power state |
| img_flush | output | 1 | Discard buffered image data |
| video_restart | output | 1 | Video resumes at a new frame |
| irq_bad_dt | output | 1 | Unsupported or unserviceable header discarded |

## Verification
A corrupted queue pointer or count shows up at once as a wrong `hs_hdr` value, a missing or extra packet, or payload bytes taken from the wrong slot in the first transfer after the fault. A wrong scheduler state shows up within one cycle as two link activities at the same time, or as a short packet sent outside a blanking slot that fits. Inside an escape sequence it shows up within the 8-cycle code window as a wrong entry code or lane set. A stale ultra-low-power state is visible as stored packets reappearing after exit, which the bench looks for within a few cycles of switching to command mode.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;

  localparam logic [7:0] LPDT_CODE   = 8'hE1;
  localparam logic [7:0] ULPS_CODE   = 8'h1E;
  localparam int unsigned LPDT_MAX   = 251;
  localparam int unsigned SHORT_BYTES = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HPAY, ST_ESC, ST_LHDR, ST_LPAY, ST_ULPS
  } st_e;

  typedef struct packed {
    logic [15:0] wc;
    logic [7:0]  dt;
  } pkt_hdr_t;

  function automatic logic is_long_dt(input logic [7:0] dt);
    return (dt == 8'h29) || (dt == 8'h39);
  endfunction

  function automatic logic is_short_dt(input logic [7:0] dt);
    case (dt)
      8'h03, 8'h13, 8'h23, 8'h05, 8'h15, 8'h06, 8'h37: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // Header acceptable for the current transport and payload capacity
  function automatic logic hdr_ok(input logic [23:0] h, input logic lp,
                                  input int unsigned cap);
    int unsigned wc;
    wc = int'(h[23:8]);
    if (is_short_dt(h[7:0])) return 1'b1;
    if (!is_long_dt(h[7:0])) return 1'b0;
    if (wc > cap) return 1'b0;
    if (lp && (wc > LPDT_MAX)) return 1'b0;
    return 1'b1;
  endfunction

  // Short packet fits when its bytes are covered by remaining cycles times lanes
  function automatic logic slot_fits(input logic [15:0] left, input int unsigned lanes);
    return (int'(left) * lanes) >= SHORT_BYTES;
  endfunction

endpackage

// File: rtl/cmdq_fifo.sv
module cmdq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          wr,
  input  logic [W-1:0]  wdata,
  input  logic          rd,
  output logic [W-1:0]  rdata,
  output logic          empty,
  output logic          full,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_wr, do_rd;

  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
  assign count = cnt;
  assign do_wr = wr && !full;
  assign do_rd = rd && !empty;
  assign rdata = mem[rp];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_wr) wp <= bump(wp);
      if (do_rd) rp <= bump(rp);
      case ({do_wr, do_rd})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wdata;
  end
endmodule

// File: rtl/cmdq_esc_ser.sv
module cmdq_esc_ser (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] code,
  output logic       vld,
  output logic       bit_o,
  output logic       last
);
  logic [7:0] sh;
  logic [3:0] left;

  assign vld   = (left != 4'd0);
  assign bit_o = sh[7];
  assign last  = (left == 4'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh   <= '0;
      left <= '0;
    end else if (start) begin
      sh   <= code;
      left <= 4'd8;
    end else if (vld) begin
      sh   <= {sh[6:0], 1'b0};
      left <= left - 4'd1;
    end
  end
endmodule

// File: rtl/cmdq_sched.sv
module cmdq_sched
  import cmdq_pkg::*;
#(
  parameter int QDEPTH = 8,
  parameter int DDEPTH = 256,
  parameter int LANES  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_cmd_mode,
  input  logic             cfg_lpdt,
  input  logic             ulps_req,
  input  logic             blank_active,
  input  logic [15:0]      blank_left,
  input  logic             hdr_wr,
  input  logic [23:0]      hdr_wdata,
  input  logic             pay_wr,
  input  logic [7:0]       pay_wdata,
  output logic             hs_start,
  output logic [23:0]      hs_hdr,
  output logic             hs_pay_vld,
  output logic [7:0]       hs_pay_byte,
  output logic             esc_code_vld,
  output logic             esc_code_bit,
  output logic [LANES-1:0] esc_data_lanes,
  output logic             esc_clk_lane,
  output logic             lp_byte_vld,
  output logic [7:0]       lp_byte,
  output logic             ulps_active,
  output logic             img_flush,
  output logic             video_restart,
  output logic             irq_bad_dt
);
  localparam int QCW = $clog2(QDEPTH+1);
  localparam int DCW = $clog2(DDEPTH+1);

  st_e         st;
  pkt_hdr_t    cur;
  logic [15:0] left;
  logic [1:0]  hidx;
  logic        esc_ulps;

  logic [23:0]    q_rdata;
  logic           q_empty, q_full;
  logic [QCW-1:0] q_count;
  logic [7:0]     d_rdata;
  logic           d_empty, d_full;
  logic [DCW-1:0] d_count;

  // Named internal events
  pkt_hdr_t head;
  logic ulps_go, idle_ok, bad_head, pay_ready, send_hs, send_lp;
  logic q_pop, d_pop, ser_vld, ser_bit, ser_last;

  assign head      = pkt_hdr_t'(q_rdata);
  assign ulps_go   = ulps_req && (st != ST_ULPS) && !((st == ST_ESC) && esc_ulps);
  assign idle_ok   = (st == ST_IDLE) && !ulps_go && !q_empty;
  assign bad_head  = idle_ok && !hdr_ok(q_rdata, cfg_lpdt, DDEPTH);
  assign pay_ready = !is_long_dt(head.dt) || ({16'b0, head.wc} <= 32'(d_count));
  assign send_hs   = idle_ok && !bad_head && !cfg_lpdt && pay_ready &&
                     (cfg_cmd_mode ||
                      (!is_long_dt(head.dt) && blank_active && slot_fits(blank_left, LANES)));
  assign send_lp   = idle_ok && !bad_head && cfg_lpdt && cfg_cmd_mode && pay_ready;
  assign q_pop     = bad_head || send_hs || send_lp;
  assign d_pop     = (st == ST_HPAY) || (st == ST_LPAY);

  cmdq_fifo #(.W(24), .DEPTH(QDEPTH)) u_hq (
    .clk(clk), .rst_n(rst_n), .flush(ulps_go),
    .wr(hdr_wr), .wdata(hdr_wdata), .rd(q_pop), .rdata(q_rdata),
    .empty(q_empty), .full(q_full), .count(q_count)
  );

  cmdq_fifo #(.W(8), .DEPTH(DDEPTH)) u_dq (
    .clk(clk), .rst_n(rst_n), .flush(ulps_go),
    .wr(pay_wr), .wdata(pay_wdata), .rd(d_pop), .rdata(d_rdata),
    .empty(d_empty), .full(d_full), .count(d_count)
  );

  cmdq_esc_ser u_ser (
    .clk(clk), .rst_n(rst_n), .start(send_lp || ulps_go),
    .code(ulps_go ? ULPS_CODE : LPDT_CODE),
    .vld(ser_vld), .bit_o(ser_bit), .last(ser_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cur      <= '0;
      left     <= '0;
      hidx     <= '0;
      esc_ulps <= 1'b0;
    end else if (ulps_go) begin
      st       <= ST_ESC;
      esc_ulps <= 1'b1;
    end else begin
      case (st)
        ST_IDLE: begin
          if (send_hs && is_long_dt(head.dt) && (head.wc != 16'd0)) begin
            st   <= ST_HPAY;
            left <= head.wc;
          end else if (send_lp) begin
            st       <= ST_ESC;
            esc_ulps <= 1'b0;
            cur      <= head;
          end
        end
        ST_HPAY, ST_LPAY: begin
          left <= left - 16'd1;
          if (left == 16'd1) st <= ST_IDLE;
        end
        ST_ESC: begin
          if (ser_last) begin
            st   <= esc_ulps ? ST_ULPS : ST_LHDR;
            hidx <= '0;
          end
        end
        ST_LHDR: begin
          hidx <= hidx + 2'd1;
          if (hidx == 2'd2) begin
            if (is_long_dt(cur.dt) && (cur.wc != 16'd0)) begin
              st   <= ST_LPAY;
              left <= cur.wc;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        ST_ULPS: if (!ulps_req) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign hs_start       = send_hs;
  assign hs_hdr         = q_rdata;
  assign hs_pay_vld     = (st == ST_HPAY);
  assign hs_pay_byte    = d_rdata;
  assign esc_code_vld   = ser_vld;
  assign esc_code_bit   = ser_bit;
  assign esc_data_lanes = !ser_vld ? '0 : (esc_ulps ? {LANES{1'b1}} : LANES'(1));
  assign esc_clk_lane   = ser_vld && esc_ulps;
  assign lp_byte_vld    = (st == ST_LHDR) || (st == ST_LPAY);
  assign lp_byte        = (st == ST_LPAY) ? d_rdata :
                          (hidx == 2'd0)  ? cur.dt  :
                          (hidx == 2'd1)  ? cur.wc[7:0] : cur.wc[15:8];
  assign ulps_active    = (st == ST_ULPS);
  assign img_flush      = ulps_go;
  assign video_restart  = (st == ST_ULPS) && !ulps_req;
  assign irq_bad_dt     = bad_head;
endmodule

// File: rtl/cmdq_sched_chk.sv
module cmdq_sched_chk
  import cmdq_pkg::*;
#(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_cmd_mode,
  input logic             ulps_req,
  input logic             blank_active,
  input logic [15:0]      blank_left,
  input logic             hs_start,
  input logic [23:0]      hs_hdr,
  input logic             hs_pay_vld,
  input logic             esc_code_vld,
  input logic [LANES-1:0] esc_data_lanes,
  input logic             esc_clk_lane,
  input logic             lp_byte_vld,
  input logic             ulps_active,
  input logic             img_flush,
  input logic             video_restart,
  input logic             irq_bad_dt,
  input logic             ulps_go
);
  // R4
  vid_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_start && !cfg_cmd_mode |->
      blank_active && (int'(blank_left) * LANES >= 4) && !is_long_dt(hs_hdr[7:0]));

  // R8
  flush_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    img_flush |=> esc_code_vld && esc_clk_lane && (esc_data_lanes == {LANES{1'b1}}));

  // R8
  ulps_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ulps_active && ulps_req |=> ulps_active);

  // R6
  lpdt_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    esc_code_vld && !esc_clk_lane |-> esc_data_lanes == LANES'(1));

  // R10
  one_activity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hs_start, hs_pay_vld, esc_code_vld, lp_byte_vld, ulps_active}));

  // R9
  exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    video_restart |=> !ulps_active);

  // R5
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_bad_dt |-> !hs_start && !ulps_go);
endmodule

bind cmdq_sched cmdq_sched_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_cmd_mode(cfg_cmd_mode), .ulps_req(ulps_req),
  .blank_active(blank_active), .blank_left(blank_left), .hs_start(hs_start),
  .hs_hdr(hs_hdr), .hs_pay_vld(hs_pay_vld), .esc_code_vld(esc_code_vld),
  .esc_data_lanes(esc_data_lanes), .esc_clk_lane(esc_clk_lane),
  .lp_byte_vld(lp_byte_vld), .ulps_active(ulps_active), .img_flush(img_flush),
  .video_restart(video_restart), .irq_bad_dt(irq_bad_dt), .ulps_go(ulps_go)
);

// File: tb/sim_cmdq_sched.sv
`timescale 1ns/1ps
module sim_cmdq_sched;
  localparam int QDEPTH = 8;
  localparam int DDEPTH = 256;
  localparam int LANES  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_cmd_mode = 1'b0, cfg_lpdt = 1'b0, ulps_req = 1'b0, blank_active = 1'b0;
  logic [15:0] blank_left = '0;
  logic hdr_wr = 1'b0, pay_wr = 1'b0;
  logic [23:0] hdr_wdata = '0;
  logic [7:0]  pay_wdata = '0;
  logic hs_start, hs_pay_vld, esc_code_vld, esc_code_bit, esc_clk_lane;
  logic lp_byte_vld, ulps_active, img_flush, video_restart, irq_bad_dt;
  logic [23:0] hs_hdr;
  logic [7:0]  hs_pay_byte, lp_byte;
  logic [LANES-1:0] esc_data_lanes;

  always #10 clk = ~clk;

  cmdq_sched #(.QDEPTH(QDEPTH), .DDEPTH(DDEPTH), .LANES(LANES)) u0 (.*);

  int n_checks = 0, n_fail = 0, n_events = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [7:0]  acc = '0;
  int          nb = 0;

  localparam logic [3:0] K_HS = 4'd1, K_HP = 4'd2, K_LP = 4'd3, K_ESC = 4'd4, K_IRQ = 4'd5;

  function automatic logic [31:0] ev(input logic [3:0] k, input logic [23:0] d);
    return {k, 4'h0, d};
  endfunction

  task automatic expect_ev(input logic [31:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic got(input logic [31:0] e);
    n_events++;
    if (exp_q.size() == 0) begin
      chk(1'b0, "unexpected output event", e, 32'h0);
    end else begin
      logic [31:0] x;
      string t;
      x = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(e == x, t, e, x);
    end
  endtask

  // Monitor: scoreboard compare at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (irq_bad_dt)  got(ev(K_IRQ, 24'h0));
      if (hs_start)    got(ev(K_HS, hs_hdr));
      if (hs_pay_vld)  got(ev(K_HP, {16'h0, hs_pay_byte}));
      if (lp_byte_vld) got(ev(K_LP, {16'h0, lp_byte}));
      if (esc_code_vld) begin
        acc = {acc[6:0], esc_code_bit};
        nb++;
        if (nb == 8) begin
          got(ev(K_ESC, {11'h0, esc_clk_lane, 4'(esc_data_lanes), acc}));
          nb = 0;
        end
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr_hdr(input logic [23:0] h);
    hdr_wr = 1'b1; hdr_wdata = h;
    step(1);
    hdr_wr = 1'b0;
  endtask

  task automatic wr_pay(input logic [7:0] b);
    pay_wr = 1'b1; pay_wdata = b;
    step(1);
    pay_wr = 1'b0;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int base;
    // R11: reset state
    step(2);
    @(negedge clk);
    chk(!hs_start && !hs_pay_vld && !esc_code_vld && !lp_byte_vld && !ulps_active &&
        !img_flush && !video_restart && !irq_bad_dt, "R11 reset outputs idle",
        {24'h0, hs_start, hs_pay_vld, esc_code_vld, lp_byte_vld, ulps_active,
         img_flush, video_restart, irq_bad_dt}, 32'h0);
    step(1);
    rst_n = 1'b1;
    step(2);

    // R2: command mode short packet
    cfg_cmd_mode = 1'b1;
    expect_ev(ev(K_HS, 24'h3A_4C15), "R2 short in command mode");
    wr_hdr(24'h3A_4C15);
    @(negedge clk);
    chk(hs_start == 1'b1, "R2 issue in cycle after write", {31'h0, hs_start}, 32'h1);
    step(3);

    // R3: long waits for payload
    base = n_events;
    wr_hdr(24'h00_0339);
    step(5);
    chk(n_events == base, "R3 long held until payload present", n_events, base);
    expect_ev(ev(K_HS, 24'h00_0339), "R3 long header");
    expect_ev(ev(K_HP, 24'h0000_C1), "R3 payload byte 0");
    expect_ev(ev(K_HP, 24'h0000_C2), "R3 payload byte 1");
    expect_ev(ev(K_HP, 24'h0000_C3), "R3 payload byte 2");
    wr_pay(8'hC1); wr_pay(8'hC2); wr_pay(8'hC3);
    step(6);

    // R5: unsupported type dropped, next packet still served
    expect_ev(ev(K_IRQ, 24'h0), "R5 bad type interrupt");
    wr_hdr(24'h11_2207);
    expect_ev(ev(K_HS, 24'h00_0105), "R5 following packet sent");
    wr_hdr(24'h00_0105);
    step(3);

    // R4: video mode blanking slot
    cfg_cmd_mode = 1'b0;
    base = n_events;
    wr_hdr(24'h00_5515);
    step(4);
    chk(n_events == base, "R4 held outside blanking", n_events, base);
    blank_active = 1'b1; blank_left = 16'd0;
    step(4);
    chk(n_events == base, "R4 held when budget 0 (0*4 < 4)", n_events, base);
    expect_ev(ev(K_HS, 24'h00_5515), "R4 sent when budget 1 (1*4 >= 4)");
    blank_left = 16'd1;
    step(3);
    // R4: long header stays queued even in blanking
    base = n_events;
    wr_pay(8'h77);
    wr_hdr(24'h00_0129);
    blank_left = 16'd100;
    step(5);
    chk(n_events == base, "R4 long held in video mode", n_events, base);
    expect_ev(ev(K_HS, 24'h00_0129), "R4 long released in command mode");
    expect_ev(ev(K_HP, 24'h0000_77), "R4 long payload");
    blank_active = 1'b0;
    cfg_cmd_mode = 1'b1;
    step(4);

    // R1: queue overflow drops extra writes, order kept
    cfg_cmd_mode = 1'b0;
    for (int i = 0; i < QDEPTH + 1; i++) begin
      if (i < QDEPTH) expect_ev(ev(K_HS, {8'h00, 8'(i), 8'h15}), "R1 queued header order");
      wr_hdr({8'h00, 8'(i), 8'h15});
    end
    cfg_cmd_mode = 1'b1;
    step(QDEPTH + 4);
    chk(exp_q.size() == 0, "R1 exactly QDEPTH headers released", exp_q.size(), 0);

    // R6: low-power short packet on lane 0
    cfg_lpdt = 1'b1;
    expect_ev(ev(K_ESC, {11'h0, 1'b0, 4'h1, 8'hE1}), "R6 entry code lane 0");
    expect_ev(ev(K_LP, 24'h0000_05), "R6 data type byte");
    expect_ev(ev(K_LP, 24'h0000_2B), "R6 word count low");
    expect_ev(ev(K_LP, 24'h0000_00), "R6 word count high");
    wr_hdr(24'h00_2B05);
    step(14);

    // R7: oversize low-power packet rejected, payload untouched
    wr_pay(8'hA0); wr_pay(8'hA1); wr_pay(8'hA2);
    expect_ev(ev(K_IRQ, 24'h0), "R7 word count 252 rejected");
    wr_hdr(24'h00FC_39);
    expect_ev(ev(K_ESC, {11'h0, 1'b0, 4'h1, 8'hE1}), "R7 entry code");
    expect_ev(ev(K_LP, 24'h0000_39), "R7 type");
    expect_ev(ev(K_LP, 24'h0000_03), "R7 count low");
    expect_ev(ev(K_LP, 24'h0000_00), "R7 count high");
    for (int i = 0; i < 3; i++) expect_ev(ev(K_LP, {16'h0, 8'hA0 + 8'(i)}), "R5 payload untouched after reject");
    wr_hdr(24'h0003_39);
    step(20);

    // R7: 251 bytes accepted
    for (int i = 0; i < 251; i++) wr_pay(8'(i));
    expect_ev(ev(K_ESC, {11'h0, 1'b0, 4'h1, 8'hE1}), "R7 entry code 251");
    expect_ev(ev(K_LP, 24'h0000_39), "R7 type 251");
    expect_ev(ev(K_LP, 24'h0000_FB), "R7 count low 251");
    expect_ev(ev(K_LP, 24'h0000_00), "R7 count high 251");
    for (int i = 0; i < 251; i++) expect_ev(ev(K_LP, {16'h0, 8'(i)}), "R7 payload 251");
    wr_hdr(24'h00FB_39);
    step(280);
    chk(exp_q.size() == 0, "R7 all 251 bytes delivered", exp_q.size(), 0);

    // R8: ultra-low-power entry clears stored packets
    cfg_lpdt = 1'b0;
    cfg_cmd_mode = 1'b0;
    wr_hdr(24'h00_0905);
    expect_ev(ev(K_ESC, {11'h0, 1'b1, 4'hF, 8'h1E}), "R8 entry code all lanes and clock");
    ulps_req = 1'b1;
    @(negedge clk);
    chk(img_flush == 1'b1, "R8 image flush on request", {31'h0, img_flush}, 32'h1);
    step(10);
    @(negedge clk);
    chk(ulps_active == 1'b1, "R8 ultra-low-power held", {31'h0, ulps_active}, 32'h1);
    step(1);
    // R9: exit
    ulps_req = 1'b0;
    @(negedge clk);
    chk(video_restart == 1'b1, "R9 restart pulse on exit", {31'h0, video_restart}, 32'h1);
    step(1);
    @(negedge clk);
    chk(ulps_active == 1'b0 && video_restart == 1'b0, "R9 state left after exit",
        {30'h0, ulps_active, video_restart}, 32'h0);
    step(1);
    base = n_events;
    cfg_cmd_mode = 1'b1;
    step(6);
    chk(n_events == base, "R8 queue emptied by entry", n_events, base);

    // R10: all expected events consumed, no other codes seen
    chk(exp_q.size() == 0, "R10 no missing events", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule